// File: doc/BRIEF.md
# Dual-Mode Parallel ADC Host Sequencer

This block sits in the host logic next to an 8-bit half-flash converter with a parallel bus. It runs the converter's strobe handshake and hands each conversion result to user logic. User logic pulses `start_i`. The block then runs one complete conversion transaction and returns the byte on `result_o` with a single-cycle `result_valid_o`. If the converter never answers, it raises a single-cycle `timeout_o` instead.

The `mode_i` input selects one of two handshake styles, and it is sampled when a transaction begins. In read-only style (mode low), the read strobe starts the conversion. The host holds read low until the converter lowers its interrupt line and releases its ready output. The shared write/ready pin is then an input, and the write-strobe output enable is off. In write-read style (mode high), a write pulse under chip-select starts the conversion. The host waits a fixed conversion time after write rises, then pulses read and samples the latched byte.

All waits are counted in system clock cycles and set by parameters. The interrupt and ready inputs pass through a two-stage synchronizer before the sequencer sees them. After each completed transaction, a recovery gap with all strobes high lets the converter release its interrupt and bus.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is high and after it, until a start is taken, `cs_n_o`, `rd_n_o` and `wr_n_o` are 1, and `busy_o`, `result_valid_o` and `timeout_o` are 0.
- R2: A start with `mode_i`=0 drives `cs_n_o` and `rd_n_o` to 0 in the next cycle. `wr_n_o` stays 1 and `wr_oe_o` is 0. Read stays low until completion has been detected.
- R3: In read-only style, completion is seen when the synchronized `int_n_i` is 0 and the synchronized `rdy_n_i` is 1. The byte on `data_i` is then captured, `result_valid_o` is 1 for exactly one cycle with `result_o` equal to that byte, and `cs_n_o`/`rd_n_o` are 1 in that cycle.
- R4: In read-only style, an interrupt that is low while ready is still 0 does not complete the transaction. The captured byte is the one present once ready returns to 1.
- R5: If read-only completion is not seen, `timeout_o` pulses for one cycle exactly TIMEOUT_CYC cycles after `rd_n_o` falls. In that cycle all strobes are 1 and `busy_o` is 0, and no `result_valid_o` is produced.
- R6: A start with `mode_i`=1 drives `cs_n_o` and `wr_n_o` to 0 together for exactly WR_PULSE_CYC cycles, with `rd_n_o` at 1 and `wr_oe_o` at 1.
- R7: In write-read style, after write rises, chip-select stays 0 with read and write at 1 for exactly CONV_WAIT_CYC cycles. Read is then 0 for exactly RD_ACCESS_CYC cycles, and the byte on `data_i` in the last of them becomes `result_o` with a one-cycle `result_valid_o`.
- R8: `busy_o` is 1 from the cycle after an accepted start until the transaction ends. A start while busy starts no second conversion and yields no second result.
- R9: The style is fixed when the start is taken. A change of `mode_i` while busy does not alter strobes, output enable or result.
- R10: After a result, `busy_o` falls exactly RECOVER_CYC cycles after `result_valid_o` is first seen, with all strobes held at 1 in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Handshake style: 0 read-only, 1 write-read |
| start_i | input | 1 | One-cycle conversion request |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | DATA_W | Last captured conversion byte |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| timeout_o | output | 1 | One-cycle strobe: converter did not answer |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| wr_n_o | output | 1 | Converter write strobe, active low |
| wr_oe_o | output | 1 | Output enable for the shared write/ready pin |
| rdy_n_i | input | 1 | Ready from the shared pin, 0 while converter is busy |
| int_n_i | input | 1 | Converter interrupt, active low |
| data_i | input | DATA_W | Converter data bus |

## Verification
The hardest corner is an interrupt that falls while ready is still low. A sequencer that ignores ready captures the idle byte instead of the conversion. The timeout is measured to the exact cycle. An off-by-one counter would fire early and cut short a slow converter, or fire late and waste bus time. A start issued mid-transaction checks that no second read is launched and no duplicate result appears. A flip of `mode_i` during a write-read transaction checks that the strobes keep the style chosen at start instead of switching half-way.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RO_WAIT,
        ST_WR_PULSE,
        ST_WR_WAIT,
        ST_WR_READ,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    function automatic strobe_t strobe_of(input seq_state_e s);
        strobe_t r;
        r = STROBE_IDLE;
        case (s)
            ST_RO_WAIT:  begin r.cs_n = 1'b0; r.rd_n = 1'b0; end
            ST_WR_PULSE: begin r.cs_n = 1'b0; r.wr_n = 1'b0; end
            ST_WR_WAIT:  r.cs_n = 1'b0;
            ST_WR_READ:  begin r.cs_n = 1'b0; r.rd_n = 1'b0; end
            default:     r = STROBE_IDLE;
        endcase
        return r;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= RST_VAL;
                else     chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= RST_VAL;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    p_load_takes_r5: assert property (@(posedge clk) disable iff (rst)
        (load_i && load_val_i != '0) |=> !expired_o);
endmodule

// File: rtl/adc_host_fsm.sv
module adc_host_fsm
    import adc_host_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CNT_W         = 10,
    parameter int unsigned TIMEOUT_CYC   = 500,
    parameter int unsigned WR_PULSE_CYC  = 20,
    parameter int unsigned CONV_WAIT_CYC = 120,
    parameter int unsigned RD_ACCESS_CYC = 10,
    parameter int unsigned RECOVER_CYC   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              int_n_s_i,
    input  logic              rdy_n_s_i,
    input  logic              expired_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output strobe_t           strobe_o,
    output logic              wr_oe_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              timeout_o
);
    localparam logic [CNT_W-1:0] LV_TIMEOUT = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] LV_PULSE   = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LV_CONV    = CNT_W'(CONV_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] LV_ACCESS  = CNT_W'(RD_ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LV_RECOVER = CNT_W'(RECOVER_CYC - 1);

    seq_state_e        state_q, state_d;
    logic              mode_q;
    logic              capture;
    logic              timeout_d;
    logic [DATA_W-1:0] result_q;
    logic              valid_q, timeout_q;

    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        capture    = 1'b0;
        timeout_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    if (mode_i) begin
                        state_d    = ST_WR_PULSE;
                        load_val_o = LV_PULSE;
                    end else begin
                        state_d    = ST_RO_WAIT;
                        load_val_o = LV_TIMEOUT;
                    end
                end
            end
            ST_RO_WAIT: begin
                if (!int_n_s_i && rdy_n_s_i) begin
                    capture    = 1'b1;
                    state_d    = ST_RECOVER;
                    load_o     = 1'b1;
                    load_val_o = LV_RECOVER;
                end else if (expired_i) begin
                    timeout_d = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_WR_PULSE: begin
                if (expired_i) begin
                    state_d    = ST_WR_WAIT;
                    load_o     = 1'b1;
                    load_val_o = LV_CONV;
                end
            end
            ST_WR_WAIT: begin
                if (expired_i) begin
                    state_d    = ST_WR_READ;
                    load_o     = 1'b1;
                    load_val_o = LV_ACCESS;
                end
            end
            ST_WR_READ: begin
                if (expired_i) begin
                    capture    = 1'b1;
                    state_d    = ST_RECOVER;
                    load_o     = 1'b1;
                    load_val_o = LV_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (expired_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mode_q    <= 1'b0;
            result_q  <= '0;
            valid_q   <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            valid_q   <= capture;
            timeout_q <= timeout_d;
            if (capture) result_q <= data_i;
            if (state_q == ST_IDLE && start_i) mode_q <= mode_i;
        end
    end

    assign strobe_o  = strobe_of(state_q);
    assign busy_o    = (state_q != ST_IDLE);
    assign wr_oe_o   = busy_o ? mode_q : mode_i;
    assign result_o  = result_q;
    assign valid_o   = valid_q;
    assign timeout_o = timeout_q;

    p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (strobe_o == STROBE_IDLE));
    p_rd_under_cs_r2: assert property (@(posedge clk) disable iff (rst)
        !strobe_o.rd_n |-> !strobe_o.cs_n);
    p_ro_pin_input_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !mode_q) |-> (!wr_oe_o && strobe_o.wr_n));
    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    p_timeout_clean_r5: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!valid_o && !busy_o && strobe_o == STROBE_IDLE));
    p_rd_wr_apart_r6: assert property (@(posedge clk) disable iff (rst)
        !(!strobe_o.rd_n && !strobe_o.wr_n));
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(mode_q));
    p_recover_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (busy_o && strobe_o == STROBE_IDLE));
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned TIMEOUT_CYC   = 500,
    parameter int unsigned WR_PULSE_CYC  = 20,
    parameter int unsigned CONV_WAIT_CYC = 120,
    parameter int unsigned RD_ACCESS_CYC = 10,
    parameter int unsigned RECOVER_CYC   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              timeout_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              wr_oe_o,
    input  logic              rdy_n_i,
    input  logic              int_n_i,
    input  logic [DATA_W-1:0] data_i
);
    localparam int unsigned LONGEST = max2(max2(TIMEOUT_CYC, WR_PULSE_CYC),
                                           max2(max2(CONV_WAIT_CYC, RD_ACCESS_CYC), RECOVER_CYC));
    localparam int unsigned CNT_W   = $clog2(max2(LONGEST, 2) + 1);

    logic [1:0]       sync_q;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    strobe_t          strobe;

    adc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({int_n_i, rdy_n_i}),
        .q_o (sync_q)
    );

    adc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    adc_host_fsm #(
        .DATA_W        (DATA_W),
        .CNT_W         (CNT_W),
        .TIMEOUT_CYC   (TIMEOUT_CYC),
        .WR_PULSE_CYC  (WR_PULSE_CYC),
        .CONV_WAIT_CYC (CONV_WAIT_CYC),
        .RD_ACCESS_CYC (RD_ACCESS_CYC),
        .RECOVER_CYC   (RECOVER_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .int_n_s_i  (sync_q[1]),
        .rdy_n_s_i  (sync_q[0]),
        .expired_i  (tmr_expired),
        .data_i     (data_i),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .strobe_o   (strobe),
        .wr_oe_o    (wr_oe_o),
        .busy_o     (busy_o),
        .result_o   (result_o),
        .valid_o    (result_valid_o),
        .timeout_o  (timeout_o)
    );

    assign cs_n_o = strobe.cs_n;
    assign rd_n_o = strobe.rd_n;
    assign wr_n_o = strobe.wr_n;

    p_result_not_timeout_r5: assert property (@(posedge clk) disable iff (rst)
        !(result_valid_o && timeout_o));
endmodule

// File: tb/adc_host_ctrl_test.sv
`timescale 1ns/1ps
module adc_host_ctrl_test;
    localparam int T_TO   = 40;
    localparam int T_WR   = 3;
    localparam int T_CONV = 10;
    localparam int T_ACC  = 2;
    localparam int T_REC  = 4;
    localparam logic [7:0] IDLE_BUS = 8'hEE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_i = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, result_valid_o, timeout_o, cs_n_o, rd_n_o, wr_n_o, wr_oe_o;
    logic [7:0] result_o;
    logic rdy_n_i = 1'b1;
    logic int_n_i = 1'b1;
    logic [7:0] data_i = IDLE_BUS;

    always #2.5 clk = ~clk;

    adc_host_ctrl #(
        .DATA_W(8), .SYNC_STAGES(2), .TIMEOUT_CYC(T_TO), .WR_PULSE_CYC(T_WR),
        .CONV_WAIT_CYC(T_CONV), .RD_ACCESS_CYC(T_ACC), .RECOVER_CYC(T_REC)
    ) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .start_i(start_i), .busy_o(busy_o),
        .result_o(result_o), .result_valid_o(result_valid_o), .timeout_o(timeout_o),
        .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .wr_oe_o(wr_oe_o),
        .rdy_n_i(rdy_n_i), .int_n_i(int_n_i), .data_i(data_i)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // converter model configuration and observations
    logic [7:0] m_val = 8'h00;
    int  m_dly = 0, m_extra = 0;
    bit  m_never = 0;
    int  ro_cnt = 0, wr_w = 0, last_wr_w = 0, gap = 0, last_gap = 0, rd_w = 0;
    int  conv_starts = 0, rd_early = 0, valid_cnt = 0;
    logic prev_rd_n = 1'b1, prev_wr_n = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!wr_oe_o) begin
                if (!cs_n_o && !rd_n_o) begin
                    if (prev_rd_n) conv_starts++;
                    ro_cnt++;
                    if (!m_never && ro_cnt >= m_dly) int_n_i = 1'b0;
                    if (!m_never && ro_cnt >= m_dly + m_extra) begin
                        rdy_n_i = 1'b1; data_i = m_val;
                    end else begin
                        rdy_n_i = 1'b0; data_i = IDLE_BUS;
                    end
                end else begin
                    if (!prev_rd_n && int_n_i && !m_never) rd_early++;
                    ro_cnt = 0; int_n_i = 1'b1; rdy_n_i = 1'b1; data_i = IDLE_BUS;
                end
            end else begin
                rdy_n_i = 1'b1;
                if (!cs_n_o && !wr_n_o) wr_w++;
                if (!prev_wr_n && wr_n_o) begin
                    last_wr_w = wr_w; wr_w = 0; gap = 0; conv_starts++;
                end
                if (!cs_n_o && wr_n_o && rd_n_o) gap++;
                if (!cs_n_o && !rd_n_o) begin
                    if (prev_rd_n) last_gap = gap;
                    rd_w++; data_i = m_val; int_n_i = 1'b0;
                end else begin
                    int_n_i = 1'b1; data_i = IDLE_BUS;
                end
            end
            prev_rd_n = rd_n_o;
            prev_wr_n = wr_n_o;
            if (result_valid_o) valid_cnt++;
        end
    end

    typedef struct packed {
        logic       md;
        logic [7:0] val;
        logic [7:0] dly;
        logic [7:0] extra;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{md: 1'b0, val: 8'h3C, dly: 8'd5,  extra: 8'd0},
        '{md: 1'b0, val: 8'hFF, dly: 8'd12, extra: 8'd0},
        '{md: 1'b0, val: 8'h00, dly: 8'd1,  extra: 8'd0},
        '{md: 1'b1, val: 8'hA5, dly: 8'd0,  extra: 8'd0},
        '{md: 1'b1, val: 8'h5A, dly: 8'd0,  extra: 8'd0},
        '{md: 1'b0, val: 8'h81, dly: 8'd6,  extra: 8'd5}
    };

    int cyc_rd_fall, cyc_end, cyc_busy_low;
    logic got_valid, got_to;
    logic [7:0] got_res;
    logic [3:0] first_strobes;

    task automatic run_txn(input logic md, input logic [7:0] val, input int dly,
                           input int extra, input bit never, input bit flip, input bit poke);
        int cyc;
        @(posedge clk);
        #1;
        m_val = val; m_dly = dly; m_extra = extra; m_never = never;
        ro_cnt = 0; wr_w = 0; last_wr_w = 0; gap = 0; last_gap = 0; rd_w = 0;
        conv_starts = 0; rd_early = 0; valid_cnt = 0;
        @(negedge clk);
        mode_i = md; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        cyc_rd_fall = 0; cyc_end = 0; cyc_busy_low = 0;
        got_valid = 0; got_to = 0; got_res = 8'h00;
        first_strobes = {cs_n_o, rd_n_o, wr_n_o, wr_oe_o};
        if (!rd_n_o) cyc_rd_fall = cyc;
        while (cyc < 300 && !got_valid && !got_to) begin
            if (result_valid_o) begin got_valid = 1; got_res = result_o; cyc_end = cyc; end
            else if (timeout_o) begin got_to = 1; cyc_end = cyc; end
            else begin
                @(negedge clk);
                cyc++;
                if (flip && cyc == 2) mode_i = ~md;
                if (poke && cyc == 4) start_i = 1'b1;
                if (poke && cyc == 5) start_i = 1'b0;
                if (cyc_rd_fall == 0 && !rd_n_o) cyc_rd_fall = cyc;
            end
        end
        if (got_valid) chk(md ? "R7 strobes released at result" : "R3 strobes released at result",
                           {30'd0, cs_n_o, rd_n_o}, 3);
        while (cyc < 400 && busy_o) begin
            @(negedge clk);
            cyc++;
            if (busy_o && !(cs_n_o && rd_n_o && wr_n_o)) chk("R10 strobes high in gap", 0, 1);
        end
        cyc_busy_low = cyc;
        mode_i = md;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {29'd0, cs_n_o, rd_n_o, wr_n_o}, 7);
        chk("R1 flags in reset", {29'd0, busy_o, result_valid_o, timeout_o}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobes after reset", {29'd0, cs_n_o, rd_n_o, wr_n_o}, 7);
        chk("R1 flags after reset", {29'd0, busy_o, result_valid_o, timeout_o}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_txn(VECS[i].md, VECS[i].val, int'(VECS[i].dly), int'(VECS[i].extra), 0, 0, 0);
            if (VECS[i].md) begin
                chk("R6 first cycle cs,rd,wr,oe", first_strobes, 4'b0101);
                chk("R6 write pulse width", last_wr_w, T_WR);
                chk("R7 wait after write", last_gap, T_CONV);
                chk("R7 read width", rd_w, T_ACC);
                chk("R7 result byte", got_res, VECS[i].val);
            end else begin
                chk("R2 first cycle cs,rd,wr,oe", first_strobes, 4'b0010);
                chk("R2 read released early", rd_early, 0);
                if (VECS[i].extra != 0) chk("R4 byte after ready", got_res, VECS[i].val);
                else chk("R3 result byte", got_res, VECS[i].val);
            end
            chk("R3 single valid pulse", valid_cnt, 1);
            chk("R5 no timeout", got_to, 0);
            chk("R10 recovery length", cyc_busy_low - cyc_end, T_REC);
        end

        // R5: converter never answers
        run_txn(1'b0, 8'h11, 0, 0, 1, 0, 0);
        chk("R5 timeout seen", got_to, 1);
        chk("R5 timeout distance", cyc_end - cyc_rd_fall, T_TO);
        chk("R5 no result", valid_cnt, 0);
        chk("R5 idle at timeout", cyc_busy_low - cyc_end, 0);

        // R8: start while busy is ignored
        run_txn(1'b0, 8'h96, 10, 0, 0, 0, 1);
        chk("R8 one conversion", conv_starts, 1);
        chk("R8 one result", valid_cnt, 1);
        chk("R8 result byte", got_res, 8'h96);
        repeat (20) @(negedge clk);
        chk("R8 no late result", {30'd0, busy_o, result_valid_o}, 0);

        // R9: mode flip during write-read
        run_txn(1'b1, 8'h3D, 0, 0, 0, 1, 0);
        chk("R9 write pulse width", last_wr_w, T_WR);
        chk("R9 wait after write", last_gap, T_CONV);
        chk("R9 result byte", got_res, 8'h3D);
        chk("R9 single result", valid_cnt, 1);

        // R9: mode flip during read-only
        run_txn(1'b0, 8'h42, 4, 0, 0, 1, 0);
        chk("R9 ro result byte", got_res, 8'h42);
        chk("R9 ro no write pulse", last_wr_w, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule